// File: doc/BRIEF.md
# Bridge Command Frame Checker

This block sits on the receive side of a bridge from a single-wire serial bus to an I2C master. Bytes of one command frame arrive one per cycle in which `byte_valid_i` is high. The block reads the leading command code, and that code alone decides which header fields follow: an address byte, a write length, payload bytes, a read length and a two-byte check value. Payload bytes are passed straight on, so a downstream I2C engine can queue them while the frame is still arriving. At the end of the frame the block issues a one-cycle descriptor: the operation kind, the stop flag, the 7-bit target address, the write count and the read count.

The frame check is a reflected CRC-16 with polynomial 0xA001 and an initial value of 0. It runs over every byte from the command code onward. The sender appends the ones' complement of the CRC, low byte first. A frame is good when the running CRC over all bytes, including the two check bytes, ends at the fixed residue. A bad check is reported in the status byte, and the descriptor is still issued. Frames are separated by a one-cycle `frame_rst_i` pulse, which clears the parser, the status and the descriptor fields.

Top module: `bcf_frame_checker`

## Requirements
- R1: After `rst_ni` or a `frame_rst_i` pulse, `status_o` is 0x00, `desc_valid_o` and `payload_valid_o` are low, and the next accepted byte is taken as a command code.
- R2: Command 0x4B (stop) and command 0x5A (no stop) are followed by an address byte (address in bits 7:1, R/W in bit 0), a length byte N and N payload bytes. Each payload byte appears on `payload_o` with `payload_valid_o` one cycle after it is accepted. The descriptor reports kind 0, the address, write count N and read count 0.
- R3: Commands 0x69 (no stop) and 0x78 (stop) have no address byte; the length byte follows the command directly. The descriptor reports kind 1 and address 0.
- R4: Command 0x87 carries an address byte, a read length M and the check bytes, with no payload. The descriptor reports kind 2, stop 1, write count 0 and read count M.
- R5: Command 0x2D carries an address byte, a write length N, N payload bytes, a read length M and the check bytes. The descriptor reports kind 3, stop 1, write count N and read count M.
- R6: `desc_valid_o` pulses one cycle after the second check byte is accepted. When the check fails, status bit 0 is set in that same cycle and the descriptor is still issued.
- R7: A write or read length of 0 sets status bit 2. No descriptor follows, and later bytes are ignored (no payload output) until `frame_rst_i`.
- R8: An unknown command code sets status bit 4. No descriptor follows, and later bytes are ignored until `frame_rst_i`.
- R9: An address byte whose bit 0 is not 1 for command 0x87, or not 0 for commands 0x4B, 0x5A and 0x2D, sets status bit 5, and the descriptor is still issued.
- R10: Configuration frames carry no check bytes and all report stop 0 and address 0. Command 0xD2 takes one data byte, forwards it as payload and issues the descriptor in the same cycle with kind 4 and write count 1. Commands 0xE1, 0x1E and 0xC4 issue the descriptor one cycle after the command byte, with kinds 5, 6 and 7 and both counts 0.
- R11: Once a descriptor has been issued, further bytes produce neither payload nor a second descriptor until `frame_rst_i`.
- R12: Status bits 1 (address not acknowledged) and 3 (bad start condition) are left at 0 for the downstream engine to fill in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_rst_i | input | 1 | Pulse that ends the current frame and clears the parser |
| byte_valid_i | input | 1 | A byte is presented on `byte_i` this cycle |
| byte_i | input | 8 | Incoming frame byte |
| payload_valid_o | output | 1 | `payload_o` holds a payload byte |
| payload_o | output | 8 | Forwarded payload byte |
| desc_valid_o | output | 1 | One-cycle pulse: the descriptor fields are complete |
| desc_kind_o | output | 3 | Operation kind code |
| desc_stop_o | output | 1 | Generate an I2C stop at the end |
| desc_addr_o | output | 7 | 7-bit I2C target address |
| desc_wr_cnt_o | output | 8 | Bytes to write |
| desc_rd_cnt_o | output | 8 | Bytes to read |
| status_o | output | 8 | Error flags of the current frame |

## Verification
The assertions assume that `frame_rst_i` and `byte_valid_i` are never high in the same cycle. They also assume that every frame starts after a `frame_rst_i` pulse, so the parser is waiting for a command code when the first byte arrives. The bench keeps to this: every frame begins with an idle cycle that carries only the reset pulse, and bytes are driven only in the cycles after it. Trailing bytes after a finished or rejected frame are sent on purpose, to show they are ignored.

// File: rtl/bcf_pkg.sv
`timescale 1ns/1ps
package bcf_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OPC_WR_STOP   = 8'h4B;
  localparam logic [7:0] OPC_WR_OPEN   = 8'h5A;
  localparam logic [7:0] OPC_DATA_OPEN = 8'h69;
  localparam logic [7:0] OPC_DATA_STOP = 8'h78;
  localparam logic [7:0] OPC_RD_STOP   = 8'h87;
  localparam logic [7:0] OPC_WRRD_STOP = 8'h2D;
  localparam logic [7:0] OPC_CFG_WR    = 8'hD2;
  localparam logic [7:0] OPC_CFG_RD    = 8'hE1;
  localparam logic [7:0] OPC_SLEEP     = 8'h1E;
  localparam logic [7:0] OPC_REV       = 8'hC4;

  localparam int ST_BIT_CRC   = 0;
  localparam int ST_BIT_LEN   = 2;
  localparam int ST_BIT_CMD   = 4;
  localparam int ST_BIT_RW    = 5;

  typedef enum logic [2:0] {
    K_WRITE  = 3'd0,
    K_DATA   = 3'd1,
    K_READ   = 3'd2,
    K_WRRD   = 3'd3,
    K_CFG_WR = 3'd4,
    K_CFG_RD = 3'd5,
    K_SLEEP  = 3'd6,
    K_REV    = 3'd7
  } op_kind_e;

  typedef struct packed {
    logic     known;
    op_kind_e kind;
    logic     stop;
    logic     has_addr;
    logic     has_wlen;
    logic     has_rlen;
    logic     expect_rd;
    logic     cfg_byte;
  } cmd_info_t;

  function automatic logic [15:0] crc16_upd(input logic [15:0] crc,
                                            input logic [7:0]  data,
                                            input logic [15:0] poly);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ poly;
      else                c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/bcf_cmd_decode.sv
`timescale 1ns/1ps
module bcf_cmd_decode
  import bcf_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd_i,
  output cmd_info_t         info_o
);
  always_comb begin
    info_o = '0;
    unique case (cmd_i)
      OPC_WR_STOP, OPC_WR_OPEN: begin
        info_o.known    = 1'b1;
        info_o.kind     = K_WRITE;
        info_o.stop     = (cmd_i == OPC_WR_STOP);
        info_o.has_addr = 1'b1;
        info_o.has_wlen = 1'b1;
      end
      OPC_DATA_OPEN, OPC_DATA_STOP: begin
        info_o.known    = 1'b1;
        info_o.kind     = K_DATA;
        info_o.stop     = (cmd_i == OPC_DATA_STOP);
        info_o.has_wlen = 1'b1;
      end
      OPC_RD_STOP: begin
        info_o.known     = 1'b1;
        info_o.kind      = K_READ;
        info_o.stop      = 1'b1;
        info_o.has_addr  = 1'b1;
        info_o.has_rlen  = 1'b1;
        info_o.expect_rd = 1'b1;
      end
      OPC_WRRD_STOP: begin
        info_o.known    = 1'b1;
        info_o.kind     = K_WRRD;
        info_o.stop     = 1'b1;
        info_o.has_addr = 1'b1;
        info_o.has_wlen = 1'b1;
        info_o.has_rlen = 1'b1;
      end
      OPC_CFG_WR: begin
        info_o.known    = 1'b1;
        info_o.kind     = K_CFG_WR;
        info_o.cfg_byte = 1'b1;
      end
      OPC_CFG_RD: begin info_o.known = 1'b1; info_o.kind = K_CFG_RD; end
      OPC_SLEEP:  begin info_o.known = 1'b1; info_o.kind = K_SLEEP;  end
      OPC_REV:    begin info_o.known = 1'b1; info_o.kind = K_REV;    end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcf_crc16.sv
`timescale 1ns/1ps
module bcf_crc16
  import bcf_pkg::*;
#(
  parameter logic [15:0] POLY = 16'hA001,
  parameter logic [15:0] INIT = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [15:0]       crc_next_o
);
  logic [15:0] crc_q;

  assign crc_next_o = crc16_upd(crc_q, byte_i, POLY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= INIT;
    else if (clear_i) crc_q <= INIT;
    else if (en_i)    crc_q <= crc_next_o;
  end
endmodule

// File: rtl/bcf_len_cnt.sv
`timescale 1ns/1ps
module bcf_len_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/bcf_frame_checker.sv
`timescale 1ns/1ps
module bcf_frame_checker
  import bcf_pkg::*;
#(
  parameter logic [15:0] CRC_POLY = 16'hA001,
  parameter logic [15:0] CRC_INIT = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_rst_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              payload_valid_o,
  output logic [BYTE_W-1:0] payload_o,
  output logic              desc_valid_o,
  output logic [2:0]        desc_kind_o,
  output logic              desc_stop_o,
  output logic [BYTE_W-2:0] desc_addr_o,
  output logic [BYTE_W-1:0] desc_wr_cnt_o,
  output logic [BYTE_W-1:0] desc_rd_cnt_o,
  output logic [7:0]        status_o
);
  localparam int ADDR_W = BYTE_W - 1;
  // complemented check bytes always drive the register to this value
  localparam logic [15:0] CRC_RESIDUE =
    crc16_upd(crc16_upd(16'h0000, 8'hFF, CRC_POLY), 8'hFF, CRC_POLY);

  typedef enum logic [3:0] {
    S_CMD, S_ADDR, S_WLEN, S_WDATA, S_RLEN, S_CRC_LO, S_CRC_HI, S_CFG, S_HALT
  } state_e;

  state_e            state_q;
  cmd_info_t         info_d;
  logic              has_wlen_q, has_rlen_q, expect_rd_q;
  op_kind_e          kind_q;
  logic              stop_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wcnt_q, rcnt_q, payload_q;
  logic              payload_valid_q, desc_valid_q;
  logic [7:0]        status_q;
  logic [15:0]       crc_next;
  logic              take, cnt_load, cnt_last;

  assign take     = byte_valid_i && !frame_rst_i && (state_q != S_HALT);
  assign cnt_load = take && (state_q == S_WLEN);

  bcf_cmd_decode u_dec (
    .cmd_i  (byte_i),
    .info_o (info_d)
  );

  bcf_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (frame_rst_i),
    .en_i       (take),
    .byte_i     (byte_i),
    .crc_next_o (crc_next)
  );

  bcf_len_cnt #(.CNT_W(BYTE_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .len_i  (byte_i),
    .dec_i  (take && (state_q == S_WDATA)),
    .last_o (cnt_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= S_CMD;
      has_wlen_q      <= 1'b0;
      has_rlen_q      <= 1'b0;
      expect_rd_q     <= 1'b0;
      kind_q          <= K_WRITE;
      stop_q          <= 1'b0;
      addr_q          <= '0;
      wcnt_q          <= '0;
      rcnt_q          <= '0;
      payload_q       <= '0;
      payload_valid_q <= 1'b0;
      desc_valid_q    <= 1'b0;
      status_q        <= '0;
    end else begin
      payload_valid_q <= 1'b0;
      desc_valid_q    <= 1'b0;
      if (frame_rst_i) begin
        state_q  <= S_CMD;
        kind_q   <= K_WRITE;
        stop_q   <= 1'b0;
        addr_q   <= '0;
        wcnt_q   <= '0;
        rcnt_q   <= '0;
        status_q <= '0;
      end else if (take) begin
        unique case (state_q)
          S_CMD: begin
            has_wlen_q  <= info_d.has_wlen;
            has_rlen_q  <= info_d.has_rlen;
            expect_rd_q <= info_d.expect_rd;
            kind_q      <= info_d.kind;
            stop_q      <= info_d.stop;
            if (!info_d.known) begin
              status_q[ST_BIT_CMD] <= 1'b1;
              state_q              <= S_HALT;
            end else if (info_d.cfg_byte) begin
              state_q <= S_CFG;
            end else if (info_d.has_addr) begin
              state_q <= S_ADDR;
            end else if (info_d.has_wlen) begin
              state_q <= S_WLEN;
            end else begin
              desc_valid_q <= 1'b1;
              state_q      <= S_HALT;
            end
          end
          S_ADDR: begin
            addr_q <= byte_i[BYTE_W-1:1];
            if (byte_i[0] != expect_rd_q) status_q[ST_BIT_RW] <= 1'b1;
            state_q <= has_wlen_q ? S_WLEN : S_RLEN;
          end
          S_WLEN: begin
            if (byte_i == '0) begin
              status_q[ST_BIT_LEN] <= 1'b1;
              state_q              <= S_HALT;
            end else begin
              wcnt_q  <= byte_i;
              state_q <= S_WDATA;
            end
          end
          S_WDATA: begin
            payload_valid_q <= 1'b1;
            payload_q       <= byte_i;
            if (cnt_last) state_q <= has_rlen_q ? S_RLEN : S_CRC_LO;
          end
          S_RLEN: begin
            if (byte_i == '0) begin
              status_q[ST_BIT_LEN] <= 1'b1;
              state_q              <= S_HALT;
            end else begin
              rcnt_q  <= byte_i;
              state_q <= S_CRC_LO;
            end
          end
          S_CRC_LO: state_q <= S_CRC_HI;
          S_CRC_HI: begin
            if (crc_next != CRC_RESIDUE) status_q[ST_BIT_CRC] <= 1'b1;
            desc_valid_q <= 1'b1;
            state_q      <= S_HALT;
          end
          S_CFG: begin
            payload_valid_q <= 1'b1;
            payload_q       <= byte_i;
            wcnt_q          <= BYTE_W'(1);
            desc_valid_q    <= 1'b1;
            state_q         <= S_HALT;
          end
          default: state_q <= S_HALT;
        endcase
      end
    end
  end

  assign payload_valid_o = payload_valid_q;
  assign payload_o       = payload_q;
  assign desc_valid_o    = desc_valid_q;
  assign desc_kind_o     = kind_q;
  assign desc_stop_o     = stop_q;
  assign desc_addr_o     = addr_q;
  assign desc_wr_cnt_o   = wcnt_q;
  assign desc_rd_cnt_o   = rcnt_q;
  assign status_o        = status_q;
endmodule

// File: rtl/bcf_checker.sv
`timescale 1ns/1ps
module bcf_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_rst_i,
  input logic       byte_valid_i,
  input logic [7:0] byte_i,
  input logic       payload_valid_o,
  input logic [7:0] payload_o,
  input logic       desc_valid_o,
  input logic [2:0] desc_kind_o,
  input logic [7:0] desc_wr_cnt_o,
  input logic [7:0] desc_rd_cnt_o,
  input logic [7:0] status_o
);
  a_r1_frame_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> (status_o == 8'h00 && !desc_valid_o && !payload_valid_o));

  a_r2_payload_needs_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    payload_valid_o |-> $past(byte_valid_i));

  a_r2_payload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    payload_valid_o |-> (payload_o == $past(byte_i)));

  a_r7_write_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && (desc_kind_o == 3'd0 || desc_kind_o == 3'd1 || desc_kind_o == 3'd3))
      |-> (desc_wr_cnt_o != 8'h00));

  a_r4_read_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && (desc_kind_o == 3'd2 || desc_kind_o == 3'd3)) |-> (desc_rd_cnt_o != 8'h00));

  a_r8_no_desc_on_bad_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] |-> !desc_valid_o);

  a_r11_single_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_valid_o |=> !desc_valid_o);
endmodule

bind bcf_frame_checker bcf_checker u_bcf_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .frame_rst_i     (frame_rst_i),
  .byte_valid_i    (byte_valid_i),
  .byte_i          (byte_i),
  .payload_valid_o (payload_valid_o),
  .payload_o       (payload_o),
  .desc_valid_o    (desc_valid_o),
  .desc_kind_o     (desc_kind_o),
  .desc_wr_cnt_o   (desc_wr_cnt_o),
  .desc_rd_cnt_o   (desc_rd_cnt_o),
  .status_o        (status_o)
);

// File: tb/bcf_frame_checker_bench.sv
`timescale 1ns/1ps
module bcf_frame_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n, frame_rst, bv;
  logic [7:0] bd;
  logic       pay_v, dsc_v, stop;
  logic [7:0] pay, wc, rc, st;
  logic [2:0] kind;
  logic [6:0] addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0]  fb[$];
  bit          fp[$];
  bit          fd[$];
  logic [15:0] crc_acc;

  always #2.5 clk = ~clk;

  bcf_frame_checker u_bcf_frame_checker (
    .clk_i(clk), .rst_ni(rst_n), .frame_rst_i(frame_rst), .byte_valid_i(bv), .byte_i(bd),
    .payload_valid_o(pay_v), .payload_o(pay), .desc_valid_o(dsc_v), .desc_kind_o(kind),
    .desc_stop_o(stop), .desc_addr_o(addr), .desc_wr_cnt_o(wc), .desc_rd_cnt_o(rc),
    .status_o(st)
  );

  function automatic logic [15:0] ref_crc(logic [15:0] c, logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] != b[i]) r = (r >> 1) ^ 16'hA001;
      else              r = r >> 1;
    end
    return r;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic add(logic [7:0] b, bit is_pay, bit is_desc);
    fb.push_back(b); fp.push_back(is_pay); fd.push_back(is_desc);
    crc_acc = ref_crc(crc_acc, b);
  endtask

  task automatic add_crc(bit corrupt);
    logic [15:0] x;
    x = ~crc_acc;
    if (corrupt) x[9] = ~x[9];
    add(x[7:0], 0, 0);
    add(x[15:8], 0, 1);
  endtask

  task automatic step(logic [7:0] b, bit exp_pay, bit exp_desc, string req);
    @(negedge clk);
    frame_rst = 1'b0; bv = 1'b1; bd = b;
    @(posedge clk); #1;
    bv = 1'b0;
    chk(req, "payload_valid", int'(pay_v), int'(exp_pay));
    chk(req, "desc_valid", int'(dsc_v), int'(exp_desc));
    if (exp_pay) chk(req, "payload", int'(pay), int'(b));
  endtask

  task automatic new_frame();
    fb.delete(); fp.delete(); fd.delete();
    crc_acc = 16'h0000;
    @(negedge clk);
    frame_rst = 1'b1; bv = 1'b0;
    @(posedge clk); #1;
    chk("R1", "status after frame reset", int'(st), 0);
    chk("R1", "desc_valid after frame reset", int'(dsc_v), 0);
    chk("R1", "payload_valid after frame reset", int'(pay_v), 0);
  endtask

  task automatic run(string req);
    foreach (fb[i]) step(fb[i], fp[i], fd[i], req);
  endtask

  task automatic chk_desc(string req, int k, int s, int a, int w, int r, int stat);
    chk(req, "kind", int'(kind), k);
    chk(req, "stop", int'(stop), s);
    chk(req, "addr", int'(addr), a);
    chk(req, "wr_cnt", int'(wc), w);
    chk(req, "rd_cnt", int'(rc), r);
    chk(req, "status", int'(st), stat);
    chk("R12", "reserved status bits", int'(st & 8'h0A), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; frame_rst = 1'b0; bv = 1'b0; bd = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status in reset", int'(st), 0);
    chk("R1", "desc_valid in reset", int'(dsc_v), 0);
    chk("R1", "payload_valid in reset", int'(pay_v), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 write with stop, then R11 trailing bytes
    new_frame();
    add(8'h4B,0,0); add(8'hA0,0,0); add(8'h03,0,0);
    add(8'h11,1,0); add(8'h22,1,0); add(8'h33,1,0); add_crc(0);
    run("R2");
    chk_desc("R2", 0, 1, 8'h50, 3, 0, 0);
    step(8'h4B, 0, 0, "R11");
    step(8'h77, 0, 0, "R11");
    chk_desc("R11", 0, 1, 8'h50, 3, 0, 0);

    // R2 write without stop
    new_frame();
    add(8'h5A,0,0); add(8'hFE,0,0); add(8'h01,0,0); add(8'h5C,1,0); add_crc(0);
    run("R2");
    chk_desc("R2", 0, 0, 8'h7F, 1, 0, 0);

    // R3 data-only continuation
    new_frame();
    add(8'h69,0,0); add(8'h02,0,0); add(8'hDE,1,0); add(8'hAD,1,0); add_crc(0);
    run("R3");
    chk_desc("R3", 1, 0, 0, 2, 0, 0);
    new_frame();
    add(8'h78,0,0); add(8'h01,0,0); add(8'h00,1,0); add_crc(0);
    run("R3");
    chk_desc("R3", 1, 1, 0, 1, 0, 0);

    // R4 read
    new_frame();
    add(8'h87,0,0); add(8'h43,0,0); add(8'h04,0,0); add_crc(0);
    run("R4");
    chk_desc("R4", 2, 1, 8'h21, 0, 4, 0);

    // R5 write-then-read, maximum read length
    new_frame();
    add(8'h2D,0,0); add(8'h20,0,0); add(8'h02,0,0);
    add(8'hAB,1,0); add(8'hCD,1,0); add(8'hFF,0,0); add_crc(0);
    run("R5");
    chk_desc("R5", 3, 1, 8'h10, 2, 255, 0);

    // R6 corrupted check still yields descriptor
    new_frame();
    add(8'h4B,0,0); add(8'hA0,0,0); add(8'h01,0,0); add(8'h99,1,0); add_crc(1);
    run("R6");
    chk_desc("R6", 0, 1, 8'h50, 1, 0, 8'h01);

    // R7 zero write length
    new_frame();
    add(8'h4B,0,0); add(8'hA0,0,0); add(8'h00,0,0);
    add(8'h12,0,0); add(8'h34,0,0); add(8'h56,0,0);
    run("R7");
    chk("R7", "status zero wlen", int'(st), 8'h04);
    // R7 zero read length
    new_frame();
    add(8'h2D,0,0); add(8'h20,0,0); add(8'h01,0,0); add(8'h55,1,0);
    add(8'h00,0,0); add(8'h11,0,0); add(8'h22,0,0);
    run("R7");
    chk("R7", "status zero rlen", int'(st), 8'h04);

    // R8 unknown command
    new_frame();
    add(8'h33,0,0); add(8'hA0,0,0); add(8'h01,0,0); add(8'h44,0,0); add(8'h55,0,0);
    run("R8");
    chk("R8", "status unknown cmd", int'(st), 8'h10);

    // R9 R/W bit mismatch
    new_frame();
    add(8'h4B,0,0); add(8'hA1,0,0); add(8'h01,0,0); add(8'h66,1,0); add_crc(0);
    run("R9");
    chk_desc("R9", 0, 1, 8'h50, 1, 0, 8'h20);
    new_frame();
    add(8'h87,0,0); add(8'h42,0,0); add(8'h02,0,0); add_crc(0);
    run("R9");
    chk_desc("R9", 2, 1, 8'h21, 0, 2, 8'h20);

    // R10 configuration frames
    new_frame();
    step(8'hD2, 0, 0, "R10");
    step(8'h02, 1, 1, "R10");
    chk_desc("R10", 4, 0, 0, 1, 0, 0);
    step(8'h01, 0, 0, "R11");
    new_frame();
    step(8'hE1, 0, 1, "R10");
    chk_desc("R10", 5, 0, 0, 0, 0, 0);
    new_frame();
    step(8'h1E, 0, 1, "R10");
    chk_desc("R10", 6, 0, 0, 0, 0, 0);
    new_frame();
    step(8'hC4, 0, 1, "R10");
    chk_desc("R10", 7, 0, 0, 0, 0, 0);
    step(8'hC4, 0, 0, "R11");

    // R1 clears status left by a failed frame
    new_frame();
    add(8'h33,0,0);
    run("R8");
    new_frame();
    chk_desc("R1", 0, 0, 0, 0, 0, 0);

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule